// File: doc/BRIEF.md
# Shadow-Banked Triple-Port Register File

This block holds the general registers of a small soft processor. Every cycle it serves two reads, both combinational, and one write that is captured on the rising clock edge. Thirty-two 32-bit entries are split into two banks of sixteen. Instructions carry 4-bit register fields, so software only ever sees sixteen registers at a time.

An interrupt-mode input steers all three accesses to the upper bank. A handler therefore has a private register set and does not need to save or restore the interrupted code's registers. To support 16-bit arithmetic, each read port can return the upper or lower half of an entry, placed in its low 16 output bits.

Storage is kept as two identical copies, one per read port, and every write updates both copies. Contents are undefined after reset. Reset only blocks writes.

Top module: `shadow_regfile`

## Requirements
- R1: Both read ports return an entry in the same cycle its address is applied, and each port reads independently of the other, including when both name the same register.
- R2: When `wr_en` is 1 at a rising edge (and `rst_n` is 1), `wr_data` is stored at the addressed entry. From the following cycle, both read ports return the stored value.
- R3: When `wr_en` is 0, no entry changes.
- R4: The physical entry index is `irq_mode*16 + field`, for the write field and for both read fields alike. Bit 4 is set while `irq_mode` is 1, and the other bank is left untouched.
- R5: When a port's half-enable is 1, that port outputs `{16'h0, half}`. The half is bits 31:16 when its high-select is 1, and bits 15:0 when the high-select is 0. When the half-enable is 0, the port outputs the full 32-bit entry.
- R6: A read of the entry being written in the same cycle returns the old value. There is no write-through; the new value appears only after the edge.
- R7: While `rst_n` is 0, writes are ignored and existing contents are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes are captured on the rising edge |
| rst_n | input | 1 | Active-low reset; blocks writes while low |
| irq_mode | input | 1 | Selects the upper bank for all accesses |
| wr_en | input | 1 | Write enable |
| wr_sel | input | 4 | Write register field |
| wr_data | input | 32 | Write data |
| rd_sel_a | input | 4 | Port A register field |
| half_a | input | 1 | Port A half-word mode |
| hi_a | input | 1 | Port A selects the upper half |
| rd_data_a | output | 32 | Port A read data |
| rd_sel_b | input | 4 | Port B register field |
| half_b | input | 1 | Port B half-word mode |
| hi_b | input | 1 | Port B selects the upper half |
| rd_data_b | output | 32 | Port B read data |

## Verification
Reads are combinational, so a read result is due in the same cycle as its address. The bench applies addresses at the falling edge and samples one time unit later, well before the next rising edge. A write result is due one edge later: the bench checks the old value before the capturing edge and the new value at the following falling edge. A value written under one bank setting is always read back under the same setting. The other bank is read afterwards to confirm it was not disturbed.

// File: rtl/shadow_regfile.sv
module shadow_regfile #(
  parameter int DW = 32,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          irq_mode,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_sel,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_sel_a,
  input  logic          half_a,
  input  logic          hi_a,
  output logic [DW-1:0] rd_data_a,
  input  logic [AW-1:0] rd_sel_b,
  input  logic          half_b,
  input  logic          hi_b,
  output logic [DW-1:0] rd_data_b
);
  localparam int PAW   = AW + 1;
  localparam int DEPTH = 1 << PAW;
  localparam int HW    = DW / 2;
  localparam int NPORT = 2;

  logic [PAW-1:0] wr_idx;
  logic [PAW-1:0] rd_idx [NPORT];
  logic           hsel   [NPORT];
  logic           hhi    [NPORT];
  logic [DW-1:0]  rd_out [NPORT];

  assign wr_idx    = {irq_mode, wr_sel};
  assign rd_idx[0] = {irq_mode, rd_sel_a};
  assign rd_idx[1] = {irq_mode, rd_sel_b};
  assign hsel[0]   = half_a;
  assign hsel[1]   = half_b;
  assign hhi[0]    = hi_a;
  assign hhi[1]    = hi_b;
  assign rd_data_a = rd_out[0];
  assign rd_data_b = rd_out[1];

  wire wr_go = wr_en & rst_n;

  for (genvar p = 0; p < NPORT; p++) begin : g_copy
    logic [DW-1:0] store [DEPTH];
    logic [DW-1:0] word;

    always_ff @(posedge clk)
      if (wr_go) store[wr_idx] <= wr_data;

    assign word = store[rd_idx[p]];
    assign rd_out[p] = !hsel[p] ? word
                     : hhi[p]  ? {{(DW-HW){1'b0}}, word[DW-1:HW]}
                               : {{(DW-HW){1'b0}}, word[HW-1:0]};
  end
endmodule

// File: rtl/shadow_regfile_chk.sv
module shadow_regfile_chk #(
  parameter int DW = 32,
  parameter int AW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          irq_mode,
  input logic          wr_en,
  input logic [AW-1:0] wr_sel,
  input logic [DW-1:0] wr_data,
  input logic [AW-1:0] rd_sel_a,
  input logic          half_a,
  input logic          hi_a,
  input logic [DW-1:0] rd_data_a,
  input logic [AW-1:0] rd_sel_b,
  input logic          half_b,
  input logic          hi_b,
  input logic [DW-1:0] rd_data_b
);
  localparam int HW = DW / 2;

  assert_write_visible_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wr_en) && $past(rst_n) && rd_sel_a == $past(wr_sel) &&
     irq_mode == $past(irq_mode) && !half_a) |-> rd_data_a == $past(wr_data));

  assert_hold_without_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((!$past(wr_en) || !$past(rst_n)) && $stable(rd_sel_a) && $stable(irq_mode) &&
     $stable(half_a) && $stable(hi_a)) |-> $stable(rd_data_a));

  assert_copies_agree_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_sel_a == rd_sel_b && !half_a && !half_b) |-> rd_data_a == rd_data_b);

  assert_half_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_sel_a == rd_sel_b && !half_a && half_b && hi_b) |->
      rd_data_b == {{(DW-HW){1'b0}}, rd_data_a[DW-1:HW]});

  assert_half_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_sel_a == rd_sel_b && half_a && !hi_a && !half_b) |->
      rd_data_a == {{(DW-HW){1'b0}}, rd_data_b[HW-1:0]});
endmodule

bind shadow_regfile shadow_regfile_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_mode(irq_mode), .wr_en(wr_en),
  .wr_sel(wr_sel), .wr_data(wr_data),
  .rd_sel_a(rd_sel_a), .half_a(half_a), .hi_a(hi_a), .rd_data_a(rd_data_a),
  .rd_sel_b(rd_sel_b), .half_b(half_b), .hi_b(hi_b), .rd_data_b(rd_data_b));

// File: tb/tb_shadow_regfile.sv
module tb_shadow_regfile;
  logic clk = 0, rst_n = 0, irq_mode = 0, wr_en = 0;
  logic [3:0] wr_sel = 0, rd_sel_a = 0, rd_sel_b = 0;
  logic [31:0] wr_data = 0;
  logic half_a = 0, hi_a = 0, half_b = 0, hi_b = 0;
  logic [31:0] rd_data_a, rd_data_b;
  logic [31:0] model [32];
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  shadow_regfile dut (
    .clk(clk), .rst_n(rst_n), .irq_mode(irq_mode), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel_a(rd_sel_a), .half_a(half_a), .hi_a(hi_a), .rd_data_a(rd_data_a),
    .rd_sel_b(rd_sel_b), .half_b(half_b), .hi_b(hi_b), .rd_data_b(rd_data_b));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(bit bank, int idx, logic [31:0] d);
    @(negedge clk);
    irq_mode = bank; wr_sel = idx[3:0]; wr_data = d; wr_en = 1;
    @(negedge clk);
    wr_en = 0;
    if (rst_n) model[{bank, idx[3:0]}] = d;
  endtask

  task automatic rd(bit bank, int ia, int ib);
    @(negedge clk);
    irq_mode = bank; rd_sel_a = ia[3:0]; rd_sel_b = ib[3:0];
    half_a = 0; half_b = 0;
    #1;
  endtask

  task automatic t_init_and_full();
    for (int b = 0; b < 2; b++)
      for (int i = 0; i < 16; i++)
        wr(b[0], i, 32'h1000_0000 * (b + 1) + 32'h0011_0000 * i + 32'h0000_0101 * (i ^ 5));
    for (int b = 0; b < 2; b++)
      for (int i = 0; i < 16; i++) begin
        rd(b[0], i, 15 - i);
        check("R2/R4 port A", rd_data_a, model[b * 16 + i]);
        check("R1 port B", rd_data_b, model[b * 16 + 15 - i]);
      end
    rd(0, 7, 7);
    check("R1 same reg", rd_data_b, rd_data_a);
  endtask

  task automatic t_half();
    for (int i = 0; i < 16; i += 5) begin
      rd(1, i, i);
      half_a = 1; hi_a = 1; half_b = 1; hi_b = 0; #1;
      check("R5 hi A", rd_data_a, {16'h0, model[16 + i][31:16]});
      check("R5 lo B", rd_data_b, {16'h0, model[16 + i][15:0]});
      hi_a = 0; hi_b = 1; #1;
      check("R5 lo A", rd_data_a, {16'h0, model[16 + i][15:0]});
      check("R5 hi B", rd_data_b, {16'h0, model[16 + i][31:16]});
      half_a = 0; #1;
      check("R5 full A", rd_data_a, model[16 + i]);
    end
  endtask

  task automatic t_no_write_through();
    logic [31:0] old = model[3];
    @(negedge clk);
    irq_mode = 0; rd_sel_a = 3; rd_sel_b = 3; half_a = 0; half_b = 0;
    wr_sel = 3; wr_data = 32'hDEAD_BEEF; wr_en = 1; #1;
    check("R6 old A", rd_data_a, old);
    check("R6 old B", rd_data_b, old);
    @(negedge clk);
    wr_en = 0; model[3] = 32'hDEAD_BEEF; #1;
    check("R6/R2 new A", rd_data_a, 32'hDEAD_BEEF);
    check("R6/R2 new B", rd_data_b, 32'hDEAD_BEEF);
  endtask

  task automatic t_we_low();
    @(negedge clk);
    irq_mode = 0; wr_sel = 9; wr_data = 32'h0BAD_0BAD; wr_en = 0;
    @(negedge clk);
    rd(0, 9, 9);
    check("R3 A", rd_data_a, model[9]);
    check("R3 B", rd_data_b, model[9]);
  endtask

  task automatic t_bank_isolation();
    wr(1, 4, 32'hC0DE_0004);
    wr(0, 12, 32'hAB12_CD34);
    rd(0, 4, 12);
    check("R4 bank0 untouched", rd_data_a, model[4]);
    check("R4 bank0 write", rd_data_b, 32'hAB12_CD34);
    rd(1, 4, 12);
    check("R4 bank1 write", rd_data_a, 32'hC0DE_0004);
    check("R4 bank1 untouched", rd_data_b, model[28]);
  endtask

  task automatic t_reset_blocks();
    @(negedge clk); rst_n = 0;
    wr(0, 1, 32'h5555_AAAA);
    wr(1, 1, 32'h5555_AAAA);
    @(negedge clk); rst_n = 1;
    rd(0, 1, 1);
    check("R7 bank0 kept", rd_data_a, model[1]);
    rd(1, 1, 1);
    check("R7 bank1 kept", rd_data_b, model[17]);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_init_and_full();
    t_half();
    t_no_write_through();
    t_we_low();
    t_bank_isolation();
    t_reset_blocks();
    finish_run();
  end

  initial begin
    #400000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end
endmodule